// File: doc/BRIEF.md
# DMA Chain Status Register

This block is the status and error-capture word of a chained DMA engine. The transfer engine sends single-cycle event pulses for two kinds of normal completion and four kinds of error. Each pulse sets its own sticky bit, and the bit stays set until software writes a one to that bit position or reset is applied. A read-only summary bit reports whether any error bit is still set. A second read-only bit mirrors the engine's active flag, which comes from the configuration logic.

When a configuration error, a chain local-bus error or a data local-bus error is held, the block drives a stop request to the transfer engine. A PCI-side fatal error is recorded but does not request a stop on its own. Software reaches the word through a single-register port. The port has a select, read and write strobes, and 32-bit data. Read data is registered and appears one cycle after the read strobe.

Top module: `dma_chain_status`

## Requirements
- R1: After reset every status bit is 0, the read data register is 0 and `stop_o` is low.
- R2: A pulse on an event input sets its bit on the next clock edge: chain done sets bit 6, transfer done sets bit 5, configuration error sets bit 3, PCI fatal sets bit 2, chain bus error sets bit 1, data bus error sets bit 0. The bit stays set with no further pulses.
- R3: When `reg_sel` and `reg_wr` are both high, a 1 in bit 6, 5, 3, 2, 1 or 0 of `reg_wdata` clears that bit on the next edge. A 0 in `reg_wdata` leaves the bit unchanged, and a write without `reg_sel` changes nothing.
- R4: When an event pulse and a write-one clear reach the same bit in the same cycle, the bit is set after the edge.
- R5: Bit 7 reads as the OR of bits 3..0. Writes to bit 7 have no effect on it. It reads 0 only when all four error bits are clear.
- R6: Bit 8 reads the value of `xfer_active_i` in the cycle of the read strobe.
- R7: Bits 31..9 and bit 4 always read 0, and writes to them have no effect.
- R8: `stop_o` is high in any cycle in which bit 3, 1 or 0 is set. With only bit 2 among the error bits set, `stop_o` is low.
- R9: A read has `reg_sel` and `reg_rd` high at a clock edge. It loads `reg_rdata` at that edge with the word as it stood before the edge. `reg_rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Address hit for this register |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data, ones clear sticky bits |
| reg_rdata | output | 32 | Registered read data |
| ev_chain_done | input | 1 | Chain finished normally (pulse) |
| ev_xfer_done | input | 1 | Data transfer finished normally (pulse) |
| ev_cfg_err | input | 1 | Control and address/count settings inconsistent (pulse) |
| ev_pci_fatal | input | 1 | PCI fatal error during chain (pulse) |
| ev_chain_bus_err | input | 1 | Local-bus error during chain processing (pulse) |
| ev_data_bus_err | input | 1 | Local-bus error during data transfer (pulse) |
| xfer_active_i | input | 1 | Transfer active flag from configuration logic |
| stop_o | output | 1 | Stop request to the transfer engine |

## Verification
Several behaviours are checked by assertions on every cycle:
- each sticky bit sets after an event and clears after an uncontested write;
- set wins over clear;
- the stop request follows the halting errors and ignores a lone PCI fatal error;
- the reserved and summary bits of read data are correct;
- the active mirror is captured at the read edge.

The bench's scenarios are needed for the rest. These include a read that overlaps a set or clear in the same cycle and returns the pre-edge word. They also include writes without select, and the summary bit staying high until the last of several error bits is cleared.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_STICKY = 6;

  // sticky vector index -> word bit position
  localparam int unsigned IX_DATA_ERR  = 0;
  localparam int unsigned IX_CHAIN_ERR = 1;
  localparam int unsigned IX_PCI_ERR   = 2;
  localparam int unsigned IX_CFG_ERR   = 3;
  localparam int unsigned IX_XFER_DONE = 4;
  localparam int unsigned IX_CHN_DONE  = 5;

  localparam int unsigned POS_SUMMARY  = 7;
  localparam int unsigned POS_ACTIVE   = 8;

  // which sticky bits force the engine to stop
  localparam logic [N_STICKY-1:0] HALT_MASK = 6'b00_1011;
  localparam logic [N_STICKY-1:0] ERR_MASK  = 6'b00_1111;

  function automatic int unsigned sticky_pos(input int unsigned ix);
    return (ix < 4) ? ix : ix + 1;
  endfunction

  function automatic logic err_summary(input logic [N_STICKY-1:0] s);
    return |(s & ERR_MASK);
  endfunction

  function automatic logic halt_needed(input logic [N_STICKY-1:0] s);
    return |(s & HALT_MASK);
  endfunction

  function automatic logic [WORD_W-1:0] compose_word(input logic [N_STICKY-1:0] s,
                                                     input logic active);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int unsigned i = 0; i < N_STICKY; i++) w[sticky_pos(i)] = s[i];
    w[POS_SUMMARY] = err_summary(s);
    w[POS_ACTIVE]  = active;
    return w;
  endfunction

  function automatic logic [N_STICKY-1:0] pick_clear(input logic [WORD_W-1:0] wd);
    logic [N_STICKY-1:0] c;
    for (int unsigned i = 0; i < N_STICKY; i++) c[i] = wd[sticky_pos(i)];
    return c;
  endfunction

endpackage

// File: rtl/dcs_sticky_bit.sv
module dcs_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  p_set_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> q_o);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/dcs_halt_logic.sv
module dcs_halt_logic
  import dcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STICKY-1:0] sticky_i,
  output logic                stop_o
);

  assign stop_o = halt_needed(sticky_i);

  p_stop_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_i[IX_DATA_ERR] |-> stop_o);
  p_stop_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_i[IX_CHAIN_ERR] |-> stop_o);
  p_stop_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_i[IX_CFG_ERR] |-> stop_o);
  p_pci_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sticky_i[IX_DATA_ERR] && !sticky_i[IX_CHAIN_ERR] && !sticky_i[IX_CFG_ERR]) |-> !stop_o);

endmodule

// File: rtl/dcs_read_port.sv
module dcs_read_port
  import dcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_hit_i,
  input  logic [N_STICKY-1:0] sticky_i,
  input  logic                active_i,
  output logic [WORD_W-1:0]   rdata_o
);

  logic [WORD_W-1:0] word_now;
  assign word_now = compose_word(sticky_i, active_i);

  always_ff @(posedge clk) begin
    if (!rst_n)        rdata_o <= '0;
    else if (rd_hit_i) rdata_o <= word_now;
  end

  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o[WORD_W-1:POS_ACTIVE+1] == '0) && !rdata_o[4]);
  p_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_i |=> (rdata_o[POS_SUMMARY] == $past(|sticky_i[3:0])));
  p_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_i |=> (rdata_o[POS_ACTIVE] == $past(active_i)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit_i |=> $stable(rdata_o));

endmodule

// File: rtl/dma_chain_status.sv
module dma_chain_status
  import dcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ev_chain_done,
  input  logic        ev_xfer_done,
  input  logic        ev_cfg_err,
  input  logic        ev_pci_fatal,
  input  logic        ev_chain_bus_err,
  input  logic        ev_data_bus_err,
  input  logic        xfer_active_i,
  output logic        stop_o
);

  // named internal events for the checkers
  logic                wr_hit;
  logic                rd_hit;
  logic [N_STICKY-1:0] set_vec;
  logic [N_STICKY-1:0] clr_vec;
  logic [N_STICKY-1:0] sticky;
  logic                wdata_unused;

  assign wr_hit = reg_sel && reg_wr;
  assign rd_hit = reg_sel && reg_rd;

  assign set_vec[IX_DATA_ERR]  = ev_data_bus_err;
  assign set_vec[IX_CHAIN_ERR] = ev_chain_bus_err;
  assign set_vec[IX_PCI_ERR]   = ev_pci_fatal;
  assign set_vec[IX_CFG_ERR]   = ev_cfg_err;
  assign set_vec[IX_XFER_DONE] = ev_xfer_done;
  assign set_vec[IX_CHN_DONE]  = ev_chain_done;

  assign clr_vec      = wr_hit ? pick_clear(reg_wdata) : '0;
  assign wdata_unused = ^{reg_wdata[31:7], reg_wdata[4]};

  for (genvar g = 0; g < N_STICKY; g++) begin : g_bit
    dcs_sticky_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[g]),
      .clr_i (clr_vec[g]),
      .q_o   (sticky[g])
    );
  end

  dcs_halt_logic u_halt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sticky_i (sticky),
    .stop_o   (stop_o)
  );

  dcs_read_port u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_hit_i (rd_hit),
    .sticky_i (sticky),
    .active_i (xfer_active_i),
    .rdata_o  (reg_rdata)
  );

  p_nosel_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_sel && set_vec == '0) |=> $stable(sticky));
  p_reset_clean_r1: assert property (@(posedge clk)
    !rst_n |=> (sticky == '0 && reg_rdata == '0));

endmodule

// File: tb/dma_chain_status_tb.sv
module dma_chain_status_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_sel, reg_wr, reg_rd;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ev_chain_done, ev_xfer_done, ev_cfg_err, ev_pci_fatal;
  logic        ev_chain_bus_err, ev_data_bus_err;
  logic        xfer_active_i;
  logic        stop_o;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model: status word held by bit position
  bit [31:0] m_word;
  bit [31:0] m_rdata;

  always #5 clk = ~clk;

  dma_chain_status u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_chain_done(ev_chain_done), .ev_xfer_done(ev_xfer_done),
    .ev_cfg_err(ev_cfg_err), .ev_pci_fatal(ev_pci_fatal),
    .ev_chain_bus_err(ev_chain_bus_err), .ev_data_bus_err(ev_data_bus_err),
    .xfer_active_i(xfer_active_i), .stop_o(stop_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [31:0] visible(input bit [31:0] w, input bit act);
    bit [31:0] v;
    v = w & 32'h0000_006F;
    v[7] = w[0] | w[1] | w[2] | w[3];
    v[8] = act;
    return v;
  endfunction

  function automatic bit exp_stop(input bit [31:0] w);
    return w[3] | w[1] | w[0];
  endfunction

  task automatic idle_inputs();
    reg_sel = 0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    ev_chain_done = 0; ev_xfer_done = 0; ev_cfg_err = 0; ev_pci_fatal = 0;
    ev_chain_bus_err = 0; ev_data_bus_err = 0;
  endtask

  // one clock: inputs already driven; model updated and outputs compared after the edge
  task automatic tick();
    bit [31:0] ev, clr;
    @(posedge clk);
    ev = '0;
    ev[6] = ev_chain_done; ev[5] = ev_xfer_done; ev[3] = ev_cfg_err;
    ev[2] = ev_pci_fatal;  ev[1] = ev_chain_bus_err; ev[0] = ev_data_bus_err;
    clr = (reg_sel && reg_wr) ? (reg_wdata & 32'h0000_006F) : '0;
    if (reg_sel && reg_rd) m_rdata = visible(m_word, xfer_active_i);
    m_word = ev | (m_word & ~clr);
    #1;
    check("R9 rdata", reg_rdata, m_rdata);
    check("R8 stop", {31'b0, stop_o}, {31'b0, exp_stop(m_word)});
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_read(input string tag);
    reg_sel = 1; reg_rd = 1;
    tick();
    check(tag, reg_rdata, visible(m_word, xfer_active_i) & 32'h0 | m_rdata);
  endtask

  task automatic do_write(input logic [31:0] d, input logic sel);
    reg_sel = sel; reg_wr = 1; reg_wdata = d;
    tick();
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    idle_inputs();
    xfer_active_i = 0;
    rst_n = 0;
    m_word = '0; m_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset rdata", reg_rdata, 32'h0);
    check("R1 reset stop", {31'b0, stop_o}, 32'h0);
    do_read("R1 reset word");
    check("R1 word zero", reg_rdata, 32'h0);

    // R2: each event sets its bit
    ev_chain_done = 1; tick(); do_read("R2 chain done");
    check("R2 bit6", reg_rdata, 32'h0000_0040);
    ev_xfer_done = 1; tick(); tick(); do_read("R2 xfer done");
    check("R2 bit5 sticky", reg_rdata, 32'h0000_0060);

    // R8: PCI fatal alone does not stop; R5 summary
    ev_pci_fatal = 1; tick();
    check("R8 pci no stop", {31'b0, stop_o}, 32'h0);
    do_read("R5 summary");
    check("R5 bit7 with pci", reg_rdata, 32'h0000_00E4);

    // R3: write 0 and write without select leave bits
    do_write(32'h0, 1'b1);
    do_write(32'hFFFF_FFFF, 1'b0);
    do_read("R3 no effect");
    check("R3 unchanged", reg_rdata, 32'h0000_00E4);

    // R5: writing bit 7 does not clear it
    do_write(32'h0000_0080, 1'b1);
    do_read("R5 w bit7");
    check("R5 bit7 stays", reg_rdata, 32'h0000_00E4);

    // R8 halting errors
    ev_data_bus_err = 1; tick();
    check("R8 data stop", {31'b0, stop_o}, 32'h1);
    ev_cfg_err = 1; tick();
    do_write(32'h0000_0001, 1'b1);
    check("R8 cfg keeps stop", {31'b0, stop_o}, 32'h1);
    do_write(32'h0000_0008, 1'b1);
    check("R8 stop drops", {31'b0, stop_o}, 32'h0);
    do_read("R5 pci only");
    check("R5 summary pci only", reg_rdata, 32'h0000_00E4);
    do_write(32'h0000_0004, 1'b1);
    do_read("R5 cleared");
    check("R5 summary clear", reg_rdata, 32'h0000_0060);

    // R4: set and clear together
    ev_chain_bus_err = 1; reg_sel = 1; reg_wr = 1; reg_wdata = 32'h0000_0002; tick();
    do_read("R4 set wins");
    check("R4 bit1 set", reg_rdata, 32'h0000_00E2);

    // R6 mirror, R7 reserved bits, R9 read returns pre-edge word
    xfer_active_i = 1;
    do_write(32'hFFFF_FFFF, 1'b1);
    do_read("R6 mirror");
    check("R6 R7 active only", reg_rdata, 32'h0000_0100);
    ev_xfer_done = 1; reg_sel = 1; reg_rd = 1; tick();
    check("R9 pre-edge", reg_rdata, 32'h0000_0100);
    tick();
    check("R9 hold", reg_rdata, 32'h0000_0100);

    // random phase compared every clock
    for (int i = 0; i < 3000; i++) begin
      ev_chain_done    = ($urandom_range(0, 9) == 0);
      ev_xfer_done     = ($urandom_range(0, 9) == 0);
      ev_cfg_err       = ($urandom_range(0, 15) == 0);
      ev_pci_fatal     = ($urandom_range(0, 11) == 0);
      ev_chain_bus_err = ($urandom_range(0, 15) == 0);
      ev_data_bus_err  = ($urandom_range(0, 15) == 0);
      xfer_active_i    = $urandom_range(0, 1);
      reg_sel          = ($urandom_range(0, 3) != 0);
      reg_rd           = $urandom_range(0, 1);
      reg_wr           = ($urandom_range(0, 3) == 0);
      reg_wdata        = $urandom;
      tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule